// File: doc/BRIEF.md
# SPI Master with Width-Packed Transmit Queue

This block is a serial peripheral interface master that sits behind a simple register-style write port. A write carries 16 bits of data and a width flag. A byte-wide write adds one entry to a four-entry transmit queue. A halfword write adds two entries: the low byte first, then the high byte. The shift engine takes entries from the queue and sends each one as a frame on MOSI. It drives SCK with idle-low polarity and first-edge capture, asserts an active-low select around the whole burst, and samples MISO into a four-entry receive queue. The frame length can be set from 4 to 8 bits. The SCK rate comes from a power-of-two prescaler on the system clock.

SCK pulses occur only for frames taken from the transmit queue. To read from a slave, software writes a dummy frame. If the transmit queue still holds data when a frame finishes, the next frame starts at the following SCK rising edge with no idle time, and the select line stays asserted.

Received frames leave the block on a valid/ready stream. An entry stays on `rx_data` with `rx_valid` high until the consumer raises `rx_ready`, and it is removed at the clock edge where both are high. A stalled consumer does not hold back the wire side. Transmission carries on, and any frame that finishes while the receive queue is full is discarded and recorded in a sticky flag. The write port has no ready signal. A write that does not fit is dropped as a whole and recorded in its own sticky flag. `clk_div` and `frame_bits` must only change while `busy` is low.

Top module: `spi_pack_master`

## Requirements
- R1: SCK is low whenever `nss_n` is high and between pulses. MOSI does not change while SCK is high. MISO is sampled on each SCK rising edge.
- R2: The frame length F is `frame_bits` limited to the range 4..8 (values below 4 act as 4, above 8 as 8). A frame sends bits F-1 down to 0 of its queue entry, most significant first, using exactly F SCK pulses.
- R3: Each SCK high phase and low phase lasts 2^`clk_div` system clock cycles, so the SCK period is 2^(`clk_div`+1) cycles. `clk_div` = 5 gives divide-by-64.
- R4: A write with `wr_en` high and `wr_half` low queues `wr_data[7:0]`. With `wr_half` high it queues `wr_data[7:0]` and then `wr_data[15:8]` as two frames in that order.
- R5: When the transmit queue is non-empty at the falling SCK edge that ends a frame, the next frame's first rising edge follows one half period later and `nss_n` stays low.
- R6: `nss_n` falls one half period before the first rising SCK edge of a burst. It rises one half period after the last falling edge, and only after a complete frame.
- R7: A received frame appears on `rx_data` with the first sampled bit at position F-1, the last at bit 0, and all higher bits zero. `rx_valid` means the receive queue is non-empty, and an entry is removed when `rx_valid` and `rx_ready` are both high at a clock edge.
- R8: Both queues hold 4 entries. `tx_empty` and `tx_full` reflect the transmit queue count. `busy` is high while the queue holds data or `nss_n` is low.
- R9: A write that needs more entries than are free at its clock edge is dropped completely and sets the sticky `tx_ovf`.
- R10: A frame that finishes while the receive queue holds 4 entries is discarded and sets the sticky `rx_ovr`.
- R11: After `rst_n` low, or one cycle after `soft_rst` high, both queues are empty, SCK is low, `nss_n` is high, and both sticky flags are clear.
- R12: The number of SCK pulses equals the sum of frame lengths of accepted entries. No pulses occur without queued data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous flush of queues, lines and flags |
| clk_div | input | 3 | Prescaler exponent; half period is 2^clk_div cycles |
| frame_bits | input | 4 | Requested frame length, limited to 4..8 |
| wr_en | input | 1 | Data write strobe |
| wr_half | input | 1 | 1: halfword write (two frames), 0: byte write |
| wr_data | input | 16 | Write data; low byte is sent first |
| rx_valid | output | 1 | Receive queue not empty |
| rx_ready | input | 1 | Consumer takes the head entry |
| rx_data | output | 8 | Head entry of the receive queue |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| nss_n | output | 1 | Active-low slave select |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| busy | output | 1 | Queue non-empty or transfer in progress |
| tx_ovf | output | 1 | Sticky: a write was dropped |
| rx_ovr | output | 1 | Sticky: a received frame was dropped |

## Verification
The bench targets four kinds of faults.

- Packing: a halfword write with the bytes swapped shows up as the wrong bit on the first SCK rising edge. A halfword write that only partly fits the queue must not leave one stray byte that later produces eight extra pulses.
- Back-to-back streaming: a frame that ends exactly as a write lands, or while earlier entries are waiting, must go straight on. A design that releases `nss_n` between queued frames, or stretches the low phase, fails the edge-interval and burst-count checks.
- Frame length limits: requests below 4 or above 8 must produce 4 or 8 pulses, and the received data must be masked to the frame length.
- Overrun and soft reset: with the receive queue left full, the fifth frame must be discarded and not overwrite the head. A soft reset in the middle of a frame must stop SCK at once, clear the sticky flags and leave no leftover entry to transmit.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL
  } spim_state_e;

  localparam int unsigned FRAME_MIN = 4;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int unsigned W = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic [1:0]     push_n,
  input  logic [2*W-1:0] push_data,
  input  logic           pop,
  output logic [W-1:0]   head,
  output logic [CW-1:0]  count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!flush) begin
      if (push_n != 2'd0) mem[wr_ptr] <= push_data[W-1:0];
      if (push_n == 2'd2) mem[wr_ptr + AW'(1)] <= push_data[2*W-1:W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_n);
      rd_ptr <= rd_ptr + AW'(pop);
      cnt_q  <= cnt_q + CW'(push_n) - CW'(pop);
    end
  end

  assign head  = mem[rd_ptr];
  assign count = cnt_q;

  // R8
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R8
  fifo_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |-> (cnt_q != '0));

  // R11
  fifo_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
endmodule

// File: rtl/spim_prescaler.sv
module spim_prescaler #(
  parameter int unsigned CODE_W = 3,
  localparam int unsigned CNT_W = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'((32'd1 << code) - 32'd1);
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else cnt <= cnt + CNT_W'(1);
  end

  // R3
  presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(code)) |-> (cnt <= limit));
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int unsigned FW = 8,
  parameter int unsigned FSEL_W = 4,
  localparam int unsigned BC_W = $clog2(FW + 1),
  localparam int unsigned IW = $clog2(FW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              tick,
  input  logic [FSEL_W-1:0] frame_sel,
  input  logic              tx_avail,
  input  logic [FW-1:0]     tx_byte,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [FW-1:0]     rx_byte,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              nss_n,
  output logic              active
);
  spim_state_e     st;
  logic            sck_q, nss_q;
  logic [FW-1:0]   tx_sh, rx_sh;
  logic [BC_W-1:0] bitcnt, fsize;
  logic [IW-1:0]   msb_idx;
  logic            last, fall, done;

  always_comb begin
    if (frame_sel < FSEL_W'(FRAME_MIN)) fsize = BC_W'(FRAME_MIN);
    else if (frame_sel > FSEL_W'(FW))   fsize = BC_W'(FW);
    else                                fsize = BC_W'(frame_sel);
  end

  assign msb_idx = IW'(fsize - BC_W'(1));
  assign last    = (bitcnt == fsize - BC_W'(1));
  assign fall    = (st == ST_SHIFT) && tick && sck_q;
  assign done    = fall && last;
  assign tx_pop  = !flush && tx_avail && ((st == ST_IDLE) || done);
  assign rx_push = !flush && done;
  assign rx_byte = rx_sh & ~({FW{1'b1}} << fsize);
  assign mosi    = (st == ST_IDLE) ? 1'b0 : tx_sh[msb_idx];
  assign sck     = sck_q;
  assign nss_n   = nss_q;
  assign active  = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sck_q <= 1'b0; nss_q <= 1'b1;
      tx_sh <= '0; rx_sh <= '0; bitcnt <= '0;
    end else if (flush) begin
      st <= ST_IDLE; sck_q <= 1'b0; nss_q <= 1'b1;
      tx_sh <= '0; rx_sh <= '0; bitcnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (tx_avail) begin
          tx_sh  <= tx_byte;
          bitcnt <= '0;
          nss_q  <= 1'b0;
          st     <= ST_LEAD;
        end
        ST_LEAD: if (tick) begin
          sck_q <= 1'b1;
          rx_sh <= {rx_sh[FW-2:0], miso};
          st    <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (sck_q) begin
            sck_q <= 1'b0;
            if (last) begin
              if (tx_avail) begin
                tx_sh  <= tx_byte;
                bitcnt <= '0;
              end else begin
                st <= ST_TRAIL;
              end
            end else begin
              tx_sh  <= tx_sh << 1;
              bitcnt <= bitcnt + BC_W'(1);
            end
          end else begin
            sck_q <= 1'b1;
            rx_sh <= {rx_sh[FW-2:0], miso};
          end
        end
        ST_TRAIL: if (tick) begin
          nss_q <= 1'b1;
          st    <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> !nss_q);

  // R1
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q)) |-> $stable(mosi));

  // R6
  nss_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nss_q) |-> !sck_q);

  // R6
  nss_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nss_q) && !$past(flush)) |-> $past(st == ST_TRAIL));
endmodule

// File: rtl/spi_pack_master.sv
module spi_pack_master #(
  parameter int unsigned FRAME_W  = 8,
  parameter int unsigned TX_DEPTH = 4,
  parameter int unsigned RX_DEPTH = 4,
  parameter int unsigned DIV_W    = 3,
  parameter int unsigned FSEL_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic [DIV_W-1:0]     clk_div,
  input  logic [FSEL_W-1:0]    frame_bits,
  input  logic                 wr_en,
  input  logic                 wr_half,
  input  logic [2*FRAME_W-1:0] wr_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [FRAME_W-1:0]   rx_data,
  output logic                 sck,
  output logic                 mosi,
  input  logic                 miso,
  output logic                 nss_n,
  output logic                 tx_empty,
  output logic                 tx_full,
  output logic                 busy,
  output logic                 tx_ovf,
  output logic                 rx_ovr
);
  localparam int unsigned TXC_W = $clog2(TX_DEPTH) + 1;
  localparam int unsigned RXC_W = $clog2(RX_DEPTH) + 1;

  logic [TXC_W-1:0]   tx_cnt, tx_free;
  logic [RXC_W-1:0]   rx_cnt;
  logic [1:0]         need, tx_push_n;
  logic               room, wr_drop;
  logic [FRAME_W-1:0] tx_head, rx_byte;
  logic               tx_pop, rx_push, rx_full, rx_pop, rx_drop;
  logic               tick, eng_active;

  assign need      = wr_half ? 2'd2 : 2'd1;
  assign tx_free   = TXC_W'(TX_DEPTH) - tx_cnt;
  assign room      = tx_free >= TXC_W'(need);
  assign tx_push_n = (wr_en && room && !soft_rst) ? need : 2'd0;
  assign wr_drop   = wr_en && !room && !soft_rst;

  assign rx_full   = (rx_cnt == RXC_W'(RX_DEPTH));
  assign rx_drop   = rx_push && rx_full;
  assign rx_valid  = (rx_cnt != '0);
  assign rx_pop    = rx_valid && rx_ready && !soft_rst;

  assign tx_empty  = (tx_cnt == '0);
  assign tx_full   = (tx_cnt == TXC_W'(TX_DEPTH));
  assign busy      = eng_active || !tx_empty;

  spim_fifo #(.W(FRAME_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push_n(tx_push_n), .push_data(wr_data), .pop(tx_pop),
    .head(tx_head), .count(tx_cnt)
  );

  spim_fifo #(.W(FRAME_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push_n({1'b0, rx_push && !rx_full}),
    .push_data({{FRAME_W{1'b0}}, rx_byte}), .pop(rx_pop),
    .head(rx_data), .count(rx_cnt)
  );

  spim_prescaler #(.CODE_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(eng_active), .code(clk_div), .tick(tick)
  );

  spim_engine #(.FW(FRAME_W), .FSEL_W(FSEL_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst), .tick(tick),
    .frame_sel(frame_bits), .tx_avail(!tx_empty), .tx_byte(tx_head),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
    .miso(miso), .sck(sck), .mosi(mosi), .nss_n(nss_n), .active(eng_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ovf <= 1'b0;
      rx_ovr <= 1'b0;
    end else if (soft_rst) begin
      tx_ovf <= 1'b0;
      rx_ovr <= 1'b0;
    end else begin
      tx_ovf <= tx_ovf | wr_drop;
      rx_ovr <= rx_ovr | rx_drop;
    end
  end

  // R11
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (nss_n && !sck && tx_empty && !rx_valid && !tx_ovf && !rx_ovr));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf && !soft_rst) |=> tx_ovf);

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_full && !soft_rst) |=> (tx_ovf && tx_full));

  // R10
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovr && !soft_rst) |=> rx_ovr);

  // R8
  busy_nss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nss_n && !sck));
endmodule

// File: tb/spi_pack_master_bench.sv
module spi_pack_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [2:0]  clk_div = 3'd0;
  logic [3:0]  frame_bits = 4'd8;
  logic        wr_en = 1'b0;
  logic        wr_half = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic [7:0]  rx_data;
  logic        sck, mosi, nss_n;
  logic        miso = 1'b0;
  logic        tx_empty, tx_full, busy, tx_ovf, rx_ovr;

  always #10 clk = ~clk;

  spi_pack_master u_spi_pack_master (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .clk_div(clk_div),
    .frame_bits(frame_bits), .wr_en(wr_en), .wr_half(wr_half), .wr_data(wr_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sck(sck), .mosi(mosi), .miso(miso), .nss_n(nss_n),
    .tx_empty(tx_empty), .tx_full(tx_full), .busy(busy),
    .tx_ovf(tx_ovf), .rx_ovr(rx_ovr)
  );

  int checks = 0;
  int errors = 0;

  function automatic void chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
    end
  endfunction

  // reference model state
  logic [7:0] exp_tx[$];
  logic [7:0] slave_q[$];
  logic [7:0] exp_rx[$];
  int  mcnt = 0, pend = 0, rxcnt_m = 0;
  bit  rx_pop_pend = 0, srst_pend = 0;
  bit  exp_tx_ovf = 0, exp_rx_ovr = 0;
  int  fsz = 8, hp = 1;
  logic [7:0] cur_tx = 8'h0, cur_sl = 8'h0;
  int  bitidx = 0;
  bit  in_frame = 0, after_nss = 0;
  int  cyc = 0, last_evt = 0, pulses = 0, bursts = 0;
  bit  sck_p = 0, nss_p = 1, mosi_p = 0;

  function automatic void start_frame();
    if (exp_tx.size() == 0) chk(1'b0, "R12 frame without queued data", 1, 0);
    cur_tx = (exp_tx.size() != 0) ? exp_tx.pop_front() : 8'h00;
    cur_sl = (slave_q.size() != 0) ? slave_q.pop_front() : 8'h00;
    bitidx = 0;
    in_frame = 1;
    miso = cur_sl[fsz-1];
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      sck_p = sck; nss_p = nss_n; mosi_p = mosi;
    end else if (srst_pend) begin
      srst_pend = 0;
      exp_tx.delete(); slave_q.delete(); exp_rx.delete();
      mcnt = 0; pend = 0; rxcnt_m = 0; rx_pop_pend = 0;
      exp_tx_ovf = 0; exp_rx_ovr = 0; in_frame = 0; miso = 1'b0;
      chk(nss_n == 1'b1, "R11 nss_n after soft reset", nss_n, 1);
      chk(sck == 1'b0, "R11 sck after soft reset", sck, 0);
      chk(tx_empty == 1'b1, "R11 tx_empty after soft reset", tx_empty, 1);
      chk(rx_valid == 1'b0, "R11 rx_valid after soft reset", rx_valid, 0);
      chk(tx_ovf == 1'b0 && rx_ovr == 1'b0, "R11 flags after soft reset", {tx_ovf, rx_ovr}, 0);
      sck_p = sck; nss_p = nss_n; mosi_p = mosi;
    end else begin
      if (nss_p && !nss_n) begin
        mcnt--; bursts++; start_frame(); last_evt = cyc; after_nss = 1;
      end
      if (!sck_p && sck) begin
        pulses++;
        chk(!nss_n, "R1 select low at rising edge", nss_n, 0);
        if (after_nss) chk(cyc - last_evt == hp, "R6 lead time", cyc - last_evt, hp);
        else if (bitidx == 0) chk(cyc - last_evt == hp, "R5 gap between frames", cyc - last_evt, hp);
        else chk(cyc - last_evt == hp, "R3 low phase", cyc - last_evt, hp);
        chk(mosi == cur_tx[fsz-1-bitidx], "R2 mosi bit", mosi, cur_tx[fsz-1-bitidx]);
        last_evt = cyc; after_nss = 0;
      end
      if (sck_p && !sck) begin
        chk(cyc - last_evt == hp, "R3 high phase", cyc - last_evt, hp);
        last_evt = cyc;
        bitidx++;
        if (bitidx == fsz) begin
          if (rxcnt_m < 4) begin
            exp_rx.push_back(cur_sl & (8'hFF >> (8 - fsz)));
            rxcnt_m++;
          end else begin
            exp_rx_ovr = 1;
          end
          if (mcnt > 0) begin mcnt--; start_frame(); end
          else in_frame = 0;
        end else begin
          miso = cur_sl[fsz-1-bitidx];
        end
      end
      if (!nss_p && nss_n) begin
        chk(!in_frame, "R6 release only after full frame", in_frame, 0);
        chk(cyc - last_evt == hp, "R6 trail time", cyc - last_evt, hp);
      end
      if (sck_p && sck) chk(mosi == mosi_p, "R1 mosi held while sck high", mosi, mosi_p);
      if (nss_n) chk(!sck, "R1 sck low while deselected", sck, 0);
      mcnt += pend; pend = 0;
      if (rx_pop_pend) begin rxcnt_m--; rx_pop_pend = 0; end
      chk(tx_empty == (mcnt == 0), "R8 tx_empty", tx_empty, mcnt == 0);
      chk(tx_full == (mcnt == 4), "R8 tx_full", tx_full, mcnt == 4);
      chk(busy == (mcnt != 0 || !nss_n), "R8 busy", busy, (mcnt != 0 || !nss_n));
      chk(rx_valid == (rxcnt_m != 0), "R7 rx_valid", rx_valid, rxcnt_m != 0);
      chk(tx_ovf == exp_tx_ovf, "R9 tx_ovf", tx_ovf, exp_tx_ovf);
      chk(rx_ovr == exp_rx_ovr, "R10 rx_ovr", rx_ovr, exp_rx_ovr);
      sck_p = sck; nss_p = nss_n; mosi_p = mosi;
    end
  end

  task automatic cfg(input int fb, input int dv);
    @(negedge clk); #1;
    frame_bits = 4'(fb); clk_div = 3'(dv);
    fsz = (fb < 4) ? 4 : (fb > 8) ? 8 : fb;
    hp = 1 << dv;
  endtask

  task automatic wr(input bit half, input logic [15:0] d);
    int need;
    @(negedge clk); #1;
    need = half ? 2 : 1;
    if (4 - mcnt >= need) begin
      exp_tx.push_back(d[7:0]);
      if (half) exp_tx.push_back(d[15:8]);
      pend = need;
    end else begin
      exp_tx_ovf = 1;
    end
    wr_en = 1'b1; wr_half = half; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); #1;
    if (exp_rx.size() == 0) begin
      chk(1'b0, "R7 unexpected read", 0, 1);
    end else begin
      logic [7:0] e;
      e = exp_rx.pop_front();
      chk(rx_valid == 1'b1, "R7 rx_valid before read", rx_valid, 1);
      chk(rx_data == e, "R7 rx_data", rx_data, e);
      rx_ready = 1'b1; rx_pop_pend = 1;
      @(posedge clk); #1;
      rx_ready = 1'b0;
    end
  endtask

  task automatic drain();
    while (exp_rx.size() != 0) rd();
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(mcnt == 0 && pend == 0 && nss_n && !in_frame));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p0, b0;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    // R11 reset state
    chk(sck == 1'b0 && nss_n == 1'b1, "R11 lines after reset", {sck, nss_n}, 1);
    chk(tx_empty && !busy && !rx_valid, "R11 queues after reset", {tx_empty, busy, rx_valid}, 4);
    chk(!tx_ovf && !rx_ovr, "R11 flags after reset", {tx_ovf, rx_ovr}, 0);

    // R12 / R5: three byte writes, 8-bit frames, fastest clock
    cfg(8, 0);
    slave_q.push_back(8'hC3); slave_q.push_back(8'h18); slave_q.push_back(8'hE7);
    p0 = pulses; b0 = bursts;
    wr(0, 16'h00A1); wr(0, 16'h005E); wr(0, 16'h0077);
    wait_idle();
    chk(pulses - p0 == 24, "R12 pulses for three bytes", pulses - p0, 24);
    chk(bursts - b0 == 1, "R5 single select window", bursts - b0, 1);
    drain();

    // R4: halfword packs two frames, low byte first
    cfg(8, 1);
    slave_q.push_back(8'h81); slave_q.push_back(8'h7E);
    p0 = pulses; b0 = bursts;
    wr(1, 16'hA55A);
    wait_idle();
    chk(pulses - p0 == 16, "R4 halfword gives two frames", pulses - p0, 16);
    chk(bursts - b0 == 1, "R5 halfword frames in one window", bursts - b0, 1);
    drain();

    // R2: 4-bit frames
    cfg(4, 2);
    slave_q.push_back(8'hFA); slave_q.push_back(8'h05); slave_q.push_back(8'h39);
    p0 = pulses;
    wr(0, 16'h003C); wr(1, 16'h96E1);
    wait_idle();
    chk(pulses - p0 == 12, "R2 4-bit frame pulses", pulses - p0, 12);
    drain();

    // R2 clamp low, R3 divide-by-64
    cfg(2, 5);
    slave_q.push_back(8'hB6);
    p0 = pulses;
    wr(0, 16'h00D9);
    wait_idle();
    chk(pulses - p0 == 4, "R2 size below range acts as 4", pulses - p0, 4);
    drain();

    // R2 clamp high
    cfg(12, 0);
    slave_q.push_back(8'h4D);
    p0 = pulses;
    wr(0, 16'h0093);
    wait_idle();
    chk(pulses - p0 == 8, "R2 size above range acts as 8", pulses - p0, 8);
    drain();

    // R9 / R10: fill transmit queue, leave receive queue undrained
    cfg(8, 7);
    for (int i = 0; i < 5; i++) slave_q.push_back(8'(8'h11 * (i + 1)));
    p0 = pulses;
    wr(0, 16'h0001); wr(0, 16'h0002); wr(0, 16'h0003); wr(0, 16'h0004);
    wr(1, 16'hEEDD);
    chk(tx_ovf == 1'b1, "R9 partial-fit halfword dropped", tx_ovf, 1);
    wr(0, 16'h0005); wr(0, 16'h0006);
    @(negedge clk); #2;
    chk(tx_full == 1'b1, "R8 queue full after fill", tx_full, 1);
    wait_idle();
    chk(pulses - p0 == 40, "R9 only accepted frames sent", pulses - p0, 40);
    chk(rx_ovr == 1'b1, "R10 overrun on fifth frame", rx_ovr, 1);
    drain();
    slave_q.delete();

    // R11: soft reset in mid-frame
    cfg(8, 3);
    wr(0, 16'h00F0); wr(0, 16'h000F);
    repeat (40) @(negedge clk);
    #1 soft_rst = 1'b1; srst_pend = 1;
    @(posedge clk); #1 soft_rst = 1'b0;
    p0 = pulses;
    repeat (60) @(negedge clk);
    chk(pulses == p0, "R12 no pulses after flush", pulses - p0, 0);
    slave_q.push_back(8'h6A);
    wr(0, 16'h00C5);
    wait_idle();
    chk(pulses - p0 == 8, "R11 normal operation after soft reset", pulses - p0, 8);
    drain();

    // R12: idle produces nothing
    p0 = pulses;
    repeat (200) @(negedge clk);
    chk(pulses == p0, "R12 idle stays quiet", pulses - p0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule